// File: doc/BRIEF.md
# Dual Bridge Fault Supervisor

This block protects two full-bridge power stages. Each bridge reports an asynchronous over-current flag, which represents the summed current of both high-side switches of that bridge. Both bridges share an unsigned supply-voltage code and a die-temperature code. For each bridge the block drives a force-off output. When that output is high, all four switches of that bridge are held off. An external per-bridge enable is gated into the same output.

An over-current event turns off only the bridge that raised it. The flag must first pass a two-sample qualification and then a programmable shutdown delay. The bridge then stays off for a programmable retry interval and re-enables by itself. A low supply (lockout) or a hot die (shutdown) turns off both bridges. Each of these two faults uses separate trip and release thresholds, so it releases with hysteresis. The block reports the live fault levels. A sticky record of every trip is kept until software clears it with a write-one-to-clear pulse. At reset both bridges are held off until the supply code first rises above the release threshold.

Supply codes are in tenths of a volt, so the defaults are trip below 60 and release above 70. Temperature codes are in degrees Celsius, so the defaults are trip above 165 and release below 150. All fault inputs pass through a two-flop synchronizer.

Top module: `bridge_fault_guard`

## Requirements
- R1: While reset is asserted and after it, `bridgeOff` is 2'b11, `uvLock` is 1 and `faultStatus` is 0, until the synchronized supply code is strictly above `UV_RELEASE_CODE`.
- R2: A supply code strictly below `UV_TRIP_CODE` sets `uvLock` and forces both bridges off three clock edges after it is applied. A code equal to `UV_TRIP_CODE` does not trip.
- R3: Once locked, `uvLock` clears only when the supply code is strictly above `UV_RELEASE_CODE`. Codes from `UV_TRIP_CODE` up to and including `UV_RELEASE_CODE` hold the present state. The latency is three edges.
- R4: A temperature code strictly above `OT_TRIP_CODE` sets `otShut` and forces both bridges off, even with both enables high. A code equal to `OT_TRIP_CODE` does not trip.
- R5: Once shut down, `otShut` clears only when the temperature code is strictly below `OT_RELEASE_CODE`. The code `OT_RELEASE_CODE` itself holds the state.
- R6: `enIn[b]` low forces `bridgeOff[b]` high in the same cycle, whatever the fault state. Bit b of every per-bridge vector belongs to bridge b.
- R7: An over-current flag that stays high for only one clock is ignored. The synchronized flag must be seen high on two consecutive edges before it counts as qualified.
- R8: A flag held high turns off only its own bridge. `bridgeOff[b]` rises on the (`OC_DELAY_CYCLES`+3)-th edge after the flag is applied. If qualification drops earlier, the delay count restarts from zero.
- R9: After an over-current trip the bridge stays off for exactly `RETRY_CYCLES` cycles and then re-enables by itself. If the flag is still high, the bridge trips again `OC_DELAY_CYCLES` edges after re-enabling.
- R10: `faultStatus` bit 0 records under-voltage trips and bit 1 records over-temperature trips. Bit 2+b records over-current trips of bridge b. A bit is set on the edge where its trip occurs. A `statusClr` bit clears its `faultStatus` bit on the next edge. A set and a clear on the same edge leave the bit set.
- R11: `ocHold[b]` is high exactly while bridge b is in its over-current retry interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enIn | input | 2 | Per-bridge external enable, high = allowed to run |
| ocFlag | input | 2 | Asynchronous per-bridge over-current flag (summed high-side current) |
| supplyCode | input | SUP_W | Supply-voltage code, 0.1 V per step |
| tempCode | input | TEMP_W | Die-temperature code, 1 °C per step |
| statusClr | input | 4 | Write-one-to-clear pulse for `faultStatus` bits |
| bridgeOff | output | 2 | Per-bridge force-off, high = all four switches off |
| uvLock | output | 1 | Under-voltage lockout active |
| otShut | output | 1 | Over-temperature shutdown active |
| ocHold | output | 2 | Per-bridge over-current retry interval active |
| faultStatus | output | 4 | Sticky trip record {oc bridge1, oc bridge0, ot, uv} |

## Verification
The sticky record can see an over-current trip strobe and a software clear for the same bit on a single edge. The bench computes the exact trip edge from the qualification and delay count, which is the (`OC_DELAY_CYCLES`+3)-th edge after the flag rises. It drives a one-cycle clear of bit 2 so that the clear is sampled on that same edge. It then expects bit 2 to read one afterwards. A second clear, issued one cycle later while the bridge is still in its retry interval, must bring the bit to zero. Together these show that the set takes priority and that the clear itself works.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  localparam int NB     = 2;
  localparam int STAT_W = NB + 2;

  typedef enum logic {
    OC_RUN  = 1'b0,
    OC_HOLD = 1'b1
  } ocState_e;

  // strobes from the control FSMs to the counters and sticky record
  typedef struct packed {
    logic [NB-1:0] dlyClr;
    logic [NB-1:0] dlyInc;
    logic [NB-1:0] retryClr;
    logic [NB-1:0] retryInc;
    logic [NB-1:0] setOc;
    logic          setUv;
    logic          setOt;
  } ctrlStrobe_t;
endpackage

// File: rtl/bfg_datapath.sv
module bfg_datapath
  import bfg_pkg::*;
#(
  parameter int SUP_W           = 8,
  parameter int TEMP_W          = 8,
  parameter int UV_TRIP_CODE    = 60,
  parameter int UV_RELEASE_CODE = 70,
  parameter int OT_TRIP_CODE    = 165,
  parameter int OT_RELEASE_CODE = 150,
  parameter int OC_DELAY_CYCLES = 300,
  parameter int RETRY_CYCLES    = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NB-1:0]     ocFlagAsync,
  input  logic [SUP_W-1:0]  supplyAsync,
  input  logic [TEMP_W-1:0] tempAsync,
  input  logic [STAT_W-1:0] statusClr,
  input  ctrlStrobe_t       strb,
  output logic [NB-1:0]     ocQual,
  output logic [NB-1:0]     dlyDone,
  output logic [NB-1:0]     retryDone,
  output logic              uvTripNow,
  output logic              uvRelNow,
  output logic              otTripNow,
  output logic              otRelNow,
  output logic [STAT_W-1:0] statusQ
);
  localparam int DLY_W   = $clog2(OC_DELAY_CYCLES + 1);
  localparam int RETRY_W = $clog2(RETRY_CYCLES + 1);
  localparam logic [SUP_W-1:0]  UV_TRIP_V = SUP_W'(UV_TRIP_CODE);
  localparam logic [SUP_W-1:0]  UV_REL_V  = SUP_W'(UV_RELEASE_CODE);
  localparam logic [TEMP_W-1:0] OT_TRIP_V = TEMP_W'(OT_TRIP_CODE);
  localparam logic [TEMP_W-1:0] OT_REL_V  = TEMP_W'(OT_RELEASE_CODE);

  // two-flop synchronizers, plus one history stage on the flags
  logic [NB-1:0]     ocS1, ocS2, ocS3;
  logic [SUP_W-1:0]  supS1, supS2;
  logic [TEMP_W-1:0] tmpS1, tmpS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocS1  <= '0;
      ocS2  <= '0;
      ocS3  <= '0;
      supS1 <= '0;
      supS2 <= '0;
      tmpS1 <= '0;
      tmpS2 <= '0;
    end else begin
      ocS1  <= ocFlagAsync;
      ocS2  <= ocS1;
      ocS3  <= ocS2;
      supS1 <= supplyAsync;
      supS2 <= supS1;
      tmpS1 <= tempAsync;
      tmpS2 <= tmpS1;
    end
  end

  // flag must be high on two consecutive synchronized samples
  assign ocQual = ocS2 & ocS3;

  // threshold comparators
  assign uvTripNow = (supS2 < UV_TRIP_V);
  assign uvRelNow  = (supS2 > UV_REL_V);
  assign otTripNow = (tmpS2 > OT_TRIP_V);
  assign otRelNow  = (tmpS2 < OT_REL_V);

  // per-bridge delay and retry counters
  for (genvar b = 0; b < NB; b++) begin : g_timer
    logic [DLY_W-1:0]   dlyCnt;
    logic [RETRY_W-1:0] retryCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 dlyCnt <= '0;
      else if (strb.dlyClr[b])   dlyCnt <= '0;
      else if (strb.dlyInc[b])   dlyCnt <= dlyCnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 retryCnt <= '0;
      else if (strb.retryClr[b]) retryCnt <= '0;
      else if (strb.retryInc[b]) retryCnt <= retryCnt + 1'b1;
    end

    assign dlyDone[b]   = (dlyCnt == DLY_W'(OC_DELAY_CYCLES - 1));
    assign retryDone[b] = (retryCnt == RETRY_W'(RETRY_CYCLES - 1));

    // retry count never runs past its terminal value
    assert_retry_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
      retryCnt <= RETRY_W'(RETRY_CYCLES - 1));

    // trip strobe lands in the record even with a coincident clear
    assert_oc_sticky_set_R10: assert property (@(posedge clk) disable iff (!rstN)
      strb.setOc[b] |=> statusQ[b+2]);
  end

  // sticky trip record: set has priority over write-one-to-clear
  logic [STAT_W-1:0] setVec;
  assign setVec = {strb.setOc, strb.setOt, strb.setUv};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~statusClr) | setVec;
  end

  assert_uv_sticky_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.setUv |=> statusQ[0]);
endmodule

// File: rtl/bfg_ctrl.sv
module bfg_ctrl
  import bfg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [NB-1:0] enIn,
  input  logic [NB-1:0] ocQual,
  input  logic [NB-1:0] dlyDone,
  input  logic [NB-1:0] retryDone,
  input  logic          uvTripNow,
  input  logic          uvRelNow,
  input  logic          otTripNow,
  input  logic          otRelNow,
  output ctrlStrobe_t   strb,
  output logic          uvLock,
  output logic          otShut,
  output logic [NB-1:0] ocHold,
  output logic [NB-1:0] bridgeOff
);
  ocState_e ocState   [NB];
  ocState_e nextState [NB];

  // supply lockout with hysteresis, locked out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      uvLock <= 1'b1;
    else if (uvLock && uvRelNow)    uvLock <= 1'b0;
    else if (!uvLock && uvTripNow)  uvLock <= 1'b1;
  end

  // thermal shutdown with hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      otShut <= 1'b0;
    else if (otShut && otRelNow)    otShut <= 1'b0;
    else if (!otShut && otTripNow)  otShut <= 1'b1;
  end

  // per-bridge over-current retry FSMs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NB; b++) ocState[b] <= OC_RUN;
    end else begin
      for (int b = 0; b < NB; b++) ocState[b] <= nextState[b];
    end
  end

  always_comb begin
    strb       = '0;
    strb.setUv = !uvLock && uvTripNow;
    strb.setOt = !otShut && otTripNow;
    for (int b = 0; b < NB; b++) begin
      nextState[b] = ocState[b];
      case (ocState[b])
        OC_RUN: begin
          if (ocQual[b]) begin
            if (dlyDone[b]) begin
              nextState[b]     = OC_HOLD;
              strb.retryClr[b] = 1'b1;
              strb.setOc[b]    = 1'b1;
            end else begin
              strb.dlyInc[b]   = 1'b1;
            end
          end else begin
            strb.dlyClr[b] = 1'b1;
          end
        end
        OC_HOLD: begin
          if (retryDone[b]) begin
            nextState[b]   = OC_RUN;
            strb.dlyClr[b] = 1'b1;
          end else begin
            strb.retryInc[b] = 1'b1;
          end
        end
        default: nextState[b] = OC_RUN;
      endcase
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) ocHold[b] = (ocState[b] == OC_HOLD);
  end

  assign bridgeOff = ~enIn | {NB{uvLock | otShut}} | ocHold;

  assert_uv_trip_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uvLock) |-> $past(uvTripNow));
  assert_uv_release_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(uvLock) |-> $past(uvRelNow));
  assert_ot_trip_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(otShut) |-> $past(otTripNow));
  assert_ot_release_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(otShut) |-> $past(otRelNow));

  for (genvar g = 0; g < NB; g++) begin : g_chk
    assert_oc_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ocHold[g]) |-> $past(ocQual[g] && dlyDone[g]));
    assert_oc_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ocHold[g]) |-> $past(retryDone[g]));
  end
endmodule

// File: rtl/bridge_fault_guard.sv
module bridge_fault_guard
  import bfg_pkg::*;
#(
  parameter int SUP_W           = 8,
  parameter int TEMP_W          = 8,
  parameter int UV_TRIP_CODE    = 60,
  parameter int UV_RELEASE_CODE = 70,
  parameter int OT_TRIP_CODE    = 165,
  parameter int OT_RELEASE_CODE = 150,
  parameter int OC_DELAY_CYCLES = 300,
  parameter int RETRY_CYCLES    = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NB-1:0]     enIn,
  input  logic [NB-1:0]     ocFlag,
  input  logic [SUP_W-1:0]  supplyCode,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [STAT_W-1:0] statusClr,
  output logic [NB-1:0]     bridgeOff,
  output logic              uvLock,
  output logic              otShut,
  output logic [NB-1:0]     ocHold,
  output logic [STAT_W-1:0] faultStatus
);
  ctrlStrobe_t   strb;
  logic [NB-1:0] ocQual, dlyDone, retryDone;
  logic          uvTripNow, uvRelNow, otTripNow, otRelNow;

  bfg_datapath #(
    .SUP_W(SUP_W), .TEMP_W(TEMP_W),
    .UV_TRIP_CODE(UV_TRIP_CODE), .UV_RELEASE_CODE(UV_RELEASE_CODE),
    .OT_TRIP_CODE(OT_TRIP_CODE), .OT_RELEASE_CODE(OT_RELEASE_CODE),
    .OC_DELAY_CYCLES(OC_DELAY_CYCLES), .RETRY_CYCLES(RETRY_CYCLES)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .ocFlagAsync(ocFlag), .supplyAsync(supplyCode), .tempAsync(tempCode),
    .statusClr(statusClr), .strb(strb),
    .ocQual(ocQual), .dlyDone(dlyDone), .retryDone(retryDone),
    .uvTripNow(uvTripNow), .uvRelNow(uvRelNow),
    .otTripNow(otTripNow), .otRelNow(otRelNow),
    .statusQ(faultStatus)
  );

  bfg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enIn(enIn),
    .ocQual(ocQual), .dlyDone(dlyDone), .retryDone(retryDone),
    .uvTripNow(uvTripNow), .uvRelNow(uvRelNow),
    .otTripNow(otTripNow), .otRelNow(otRelNow),
    .strb(strb), .uvLock(uvLock), .otShut(otShut),
    .ocHold(ocHold), .bridgeOff(bridgeOff)
  );
endmodule

// File: tb/bridge_fault_guard_tb_top.sv
`timescale 1ns/1ps
module bridge_fault_guard_tb_top;
  localparam int D   = 4;
  localparam int RET = 40;
  localparam int T   = D + 3;   // edge on which an over-current trip lands

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] enIn, ocFlag, bridgeOff, ocHold;
  logic [7:0] supplyCode, tempCode;
  logic [3:0] statusClr, faultStatus;
  logic       uvLock, otShut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bridge_fault_guard #(.OC_DELAY_CYCLES(D), .RETRY_CYCLES(RET)) dut_i (
    .clk(clk), .rstN(rstN), .enIn(enIn), .ocFlag(ocFlag),
    .supplyCode(supplyCode), .tempCode(tempCode), .statusClr(statusClr),
    .bridgeOff(bridgeOff), .uvLock(uvLock), .otShut(otShut),
    .ocHold(ocHold), .faultStatus(faultStatus)
  );

  typedef struct packed {
    logic [7:0] sup;
    logic [7:0] tmp;
    logic [1:0] en;
    logic [3:0] wt;
    logic [1:0] expOff;
    logic       expUv;
    logic       expOt;
    logic [3:0] req;
  } vec_t;

  // supply / temperature / enable walk; tags: R2 R3 R4 R5 R6
  localparam vec_t VECS [0:13] = '{
    '{8'd70,  8'd25,  2'b11, 4'd3, 2'b11, 1'b1, 1'b0, 4'd3}, // R3 equal to release: stays locked
    '{8'd71,  8'd25,  2'b11, 4'd3, 2'b00, 1'b0, 1'b0, 4'd3}, // R3 release
    '{8'd60,  8'd25,  2'b11, 4'd3, 2'b00, 1'b0, 1'b0, 4'd2}, // R2 equal to trip: no lock
    '{8'd59,  8'd25,  2'b11, 4'd3, 2'b11, 1'b1, 1'b0, 4'd2}, // R2 trip
    '{8'd70,  8'd25,  2'b11, 4'd3, 2'b11, 1'b1, 1'b0, 4'd3}, // R3 hold inside band
    '{8'd90,  8'd25,  2'b11, 4'd3, 2'b00, 1'b0, 1'b0, 4'd3}, // R3 release
    '{8'd90,  8'd165, 2'b11, 4'd3, 2'b00, 1'b0, 1'b0, 4'd4}, // R4 equal to trip: runs
    '{8'd90,  8'd166, 2'b11, 4'd3, 2'b11, 1'b0, 1'b1, 4'd4}, // R4 trip with enables high
    '{8'd90,  8'd150, 2'b11, 4'd3, 2'b11, 1'b0, 1'b1, 4'd5}, // R5 equal to release: held
    '{8'd90,  8'd149, 2'b11, 4'd3, 2'b00, 1'b0, 1'b0, 4'd5}, // R5 release
    '{8'd90,  8'd25,  2'b10, 4'd1, 2'b01, 1'b0, 1'b0, 4'd6}, // R6 bridge0 disabled
    '{8'd90,  8'd25,  2'b01, 4'd1, 2'b10, 1'b0, 1'b0, 4'd6}, // R6 bridge1 disabled
    '{8'd40,  8'd25,  2'b01, 4'd3, 2'b11, 1'b1, 1'b0, 4'd2}, // R2 lock overrides enable
    '{8'd90,  8'd25,  2'b11, 4'd3, 2'b00, 1'b0, 1'b0, 4'd3}  // R3 back to running
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    rstN = 1'b0; enIn = 2'b11; ocFlag = 2'b00;
    supplyCode = 8'd0; tempCode = 8'd25; statusClr = 4'b0000;
    tick(4);
    // R1 reset state
    check("R1 reset off/uv/status", {bridgeOff, uvLock, faultStatus},
          {2'b11, 1'b1, 4'b0000});
    rstN = 1'b1;
    tick(5);
    check("R1 held off below release", {bridgeOff, uvLock}, {2'b11, 1'b1});

    for (int i = 0; i < 14; i++) begin
      supplyCode = VECS[i].sup;
      tempCode   = VECS[i].tmp;
      enIn       = VECS[i].en;
      tick(VECS[i].wt);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {bridgeOff, uvLock, otShut},
            {VECS[i].expOff, VECS[i].expUv, VECS[i].expOt});
    end

    // R10 sticky record and write-one-to-clear
    check("R10 sticky uv/ot", faultStatus, 4'b0011);
    statusClr = 4'b0001; tick(1); statusClr = 4'b0000;
    check("R10 clear uv bit", faultStatus, 4'b0010);
    statusClr = 4'b1111; tick(1); statusClr = 4'b0000;
    check("R10 clear all", faultStatus, 4'b0000);

    // R7 single-cycle flag ignored
    ocFlag[0] = 1'b1; tick(1); ocFlag[0] = 1'b0; tick(20);
    check("R7 one-cycle pulse ignored", {bridgeOff, faultStatus}, {2'b00, 4'b0000});

    // R8 two-cycle pulse: delay restarts, no trip
    ocFlag[0] = 1'b1; tick(2); ocFlag[0] = 1'b0; tick(20);
    check("R8 short qualified pulse no trip", {bridgeOff, faultStatus}, {2'b00, 4'b0000});

    // R8 exact trip edge, R11 hold level, R9 retry length
    ocFlag[0] = 1'b1; tick(T - 1);
    check("R8 not yet tripped", bridgeOff, 2'b00);
    tick(1);
    check("R8 bridge0 only off", bridgeOff, 2'b01);
    check("R11 hold level", ocHold, 2'b01);
    check("R10 oc0 recorded", faultStatus, 4'b0100);
    ocFlag[0] = 1'b0;
    tick(RET - 1);
    check("R9 still off at end of retry", bridgeOff, 2'b01);
    tick(1);
    check("R9 re-enabled", {bridgeOff, ocHold}, {2'b00, 2'b00});

    // R9 persistent flag on bridge1 re-trips after retry
    statusClr = 4'b1111; tick(1); statusClr = 4'b0000;
    ocFlag[1] = 1'b1; tick(T);
    check("R8 bridge1 only off", bridgeOff, 2'b10);
    tick(RET);
    check("R9 bridge1 retried", bridgeOff, 2'b00);
    tick(D - 1);
    check("R9 before re-trip", bridgeOff, 2'b00);
    tick(1);
    check("R9 re-trip", bridgeOff, 2'b10);
    ocFlag[1] = 1'b0;
    tick(RET + 2);
    check("R9 recovered", bridgeOff, 2'b00);

    // R10 set and clear on the same edge: set wins
    statusClr = 4'b1111; tick(1); statusClr = 4'b0000;
    ocFlag[0] = 1'b1; tick(T - 1);
    statusClr = 4'b0100; tick(1); statusClr = 4'b0000;
    check("R10 set beats clear", faultStatus, 4'b0100);
    ocFlag[0] = 1'b0;
    statusClr = 4'b0100; tick(1); statusClr = 4'b0000;
    check("R10 clear during hold", {faultStatus, ocHold}, {4'b0000, 2'b01});
    tick(RET + 2);
    check("R9 recovered after set/clear", bridgeOff, 2'b00);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule